// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single requests from a core into timed read or write cycles on an external memory or peripheral bus. Each cycle has three phases. In the lead phase the address and chip select are set up. In the active phase the read or write strobe is low. In the trail phase the address and chip select are held after the strobe rises. Reads and writes each have their own set of three phase lengths, counted in clock cycles. A global doubling control multiplies all of these lengths by two.

The external device can stretch the active phase with a ready input. Ready is used only when it is enabled. It can then be taken straight from the pin, or through a two-stage synchronizer for devices that are not clocked by the bus clock. The core pulses `req` for one cycle with the direction, address and write data. It then waits for the one-cycle `ack`. For reads, `rd_data` is valid when `ack` is high, and it keeps that value until the next read completes.

Top module: `xbus_seq`

## Requirements
- R1: `ext_cs_n` is low from the first lead cycle through the last trail cycle. During that time `ext_addr` holds the address that was accepted with the request.
- R2: For reads the phase lengths come from the `cfg_rd_*` fields, and for writes from the `cfg_wr_*` fields. A lead or trail field of zero removes that phase, so `ext_cs_n` is low for lead + active + trail cycles, plus any wait cycles.
- R3: A programmed active length of zero still gives one strobe cycle.
- R4: When `cfg_x2` is 1, every programmed phase length is multiplied by two.
- R5: The strobe is low only in the active phase. Reads drive `ext_rd_n` and writes drive `ext_wr_n`, never both. `ext_wdata` carries the request's write data while `ext_wr_n` is low.
- R6: When `cfg_use_rdy` is 0, the active phase lasts exactly its programmed length and `ext_rdy` has no effect.
- R7: When `cfg_use_rdy` is 1 and `cfg_rdy_async` is 0, ready is checked directly in the last programmed active cycle and in every later one. Each low sample adds one strobe cycle, so the strobe rises after the first cycle in which ready is high.
- R8: When `cfg_use_rdy` is 1 and `cfg_rdy_async` is 1, ready passes through two flops first. A rise of `ext_rdy` that is set up before a clock edge ends the active phase two cycles later than in synchronous mode.
- R9: `ack` is high for exactly one cycle. That cycle is the first cycle after the trail phase, or after the active phase when there is no trail, and `ext_cs_n` is already high in it.
- R10: Read data is captured from `ext_rdata` at the clock edge that ends the active phase. `rd_data` keeps that value until the next read. Writes leave it unchanged.
- R11: After reset, `ext_cs_n`, `ext_rd_n` and `ext_wr_n` are high, `ack` is low and `rd_data` is zero.
- R12: A `req` pulse that arrives while a cycle is in progress is ignored. It starts no second cycle and does not change the address on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request from the core, taken only when idle |
| req_we | input | 1 | Request direction, 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Data captured by the last read |
| cfg_rd_lead | input | CNT_W | Read lead length in cycles |
| cfg_rd_act | input | CNT_W | Read active length in cycles |
| cfg_rd_trail | input | CNT_W | Read trail length in cycles |
| cfg_wr_lead | input | CNT_W | Write lead length in cycles |
| cfg_wr_act | input | CNT_W | Write active length in cycles |
| cfg_wr_trail | input | CNT_W | Write trail length in cycles |
| cfg_x2 | input | 1 | Multiplies every phase length by two |
| cfg_use_rdy | input | 1 | Lets ready stretch the active phase |
| cfg_rdy_async | input | 1 | 0 = ready taken directly, 1 = ready through the two-flop synchronizer |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_rdata | input | DATA_W | External read data |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rdy | input | 1 | Ready from the external device |

## Verification
A phase counter that loads the wrong value, or a phase machine that takes a wrong transition, changes how many cycles `ext_cs_n` or a strobe stays low. It therefore shows up within the same access, at the latest by the cycle in which `ack` should have come. A fault in the ready path appears only when ready is enabled and low at the end of the programmed active count. It shows as a strobe that is too short or too long by one or more cycles, or by exactly two cycles for a missing or extra synchronizer stage. A capture register that samples at the wrong edge returns the value that the external bus carried after the strobe rose. That value is visible on `rd_data` as soon as `ack` is high.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_TRAIL  = 2'd3
    } phase_e;

endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_in,
    input  logic async_mode,
    output logic rdy_smp
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = rdy_in;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], rdy_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rdy_smp = async_mode ? sync_q[STAGES-1] : rdy_in;

    // Counts clock edges since reset so that $past never reaches back before it.
    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    generate
        if (STAGES == 2) begin : g_chk
            assert_sync_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3 && async_mode) |-> (rdy_smp == $past(rdy_in, 2)));
        end
    endgenerate

endmodule

// File: rtl/xbus_len_sel.sv
module xbus_len_sel #(
    parameter int CNT_W    = 3,
    parameter bit ALLOW_X2 = 1'b1,
    localparam int LW      = CNT_W + 1
) (
    input  logic             sel_we,
    input  logic [CNT_W-1:0] rd_lead,
    input  logic [CNT_W-1:0] rd_act,
    input  logic [CNT_W-1:0] rd_trail,
    input  logic [CNT_W-1:0] wr_lead,
    input  logic [CNT_W-1:0] wr_act,
    input  logic [CNT_W-1:0] wr_trail,
    input  logic             x2,
    output logic [LW-1:0]    lead_len,
    output logic [LW-1:0]    act_len,
    output logic [LW-1:0]    trail_len
);

    logic [CNT_W-1:0] f_lead, f_act, f_trail;
    logic [LW-1:0]    s_lead, s_act, s_trail;

    always_comb begin
        f_lead  = sel_we ? wr_lead  : rd_lead;
        f_act   = sel_we ? wr_act   : rd_act;
        f_trail = sel_we ? wr_trail : rd_trail;
    end

    generate
        if (ALLOW_X2) begin : g_scale
            always_comb begin
                s_lead  = x2 ? {f_lead,  1'b0} : {1'b0, f_lead};
                s_act   = x2 ? {f_act,   1'b0} : {1'b0, f_act};
                s_trail = x2 ? {f_trail, 1'b0} : {1'b0, f_trail};
            end
        end else begin : g_plain
            always_comb begin
                s_lead  = {1'b0, f_lead};
                s_act   = {1'b0, f_act};
                s_trail = {1'b0, f_trail};
            end
        end
    endgenerate

    always_comb begin
        lead_len  = s_lead;
        trail_len = s_trail;
        act_len   = (s_act == '0) ? LW'(1) : s_act;
    end

endmodule

// File: rtl/xbus_core.sv
module xbus_core
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LW-1:0]     lead_len,
    input  logic [LW-1:0]     act_len,
    input  logic [LW-1:0]     trail_len,
    input  logic              use_rdy,
    input  logic              rdy_smp,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              sel_we,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);

    typedef struct packed {
        phase_e            ph;
        logic [LW-1:0]     cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } seq_t;

    seq_t seq_d, seq_q;

    // Lengths are chosen for the new request while idle, else for the running one.
    assign sel_we = (seq_q.ph == PH_IDLE) ? req_we : seq_q.we;

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req) begin
                    seq_d.we    = req_we;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    if (lead_len != '0) begin
                        seq_d.ph  = PH_LEAD;
                        seq_d.cnt = lead_len - LW'(1);
                    end else begin
                        seq_d.ph  = PH_ACTIVE;
                        seq_d.cnt = act_len - LW'(1);
                    end
                end
            end
            PH_LEAD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_ACTIVE;
                    seq_d.cnt = act_len - LW'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - LW'(1);
                end
            end
            PH_ACTIVE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - LW'(1);
                end else if (use_rdy && !rdy_smp) begin
                    seq_d.cnt = seq_q.cnt;
                end else begin
                    if (!seq_q.we) seq_d.rdata = ext_rdata;
                    if (trail_len != '0) begin
                        seq_d.ph  = PH_TRAIL;
                        seq_d.cnt = trail_len - LW'(1);
                    end else begin
                        seq_d.ph  = PH_IDLE;
                        seq_d.ack = 1'b1;
                    end
                end
            end
            PH_TRAIL: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.ack = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - LW'(1);
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ack       = seq_q.ack;
    assign rd_data   = seq_q.rdata;
    assign ext_addr  = seq_q.addr;
    assign ext_wdata = seq_q.wdata;
    assign ext_cs_n  = (seq_q.ph == PH_IDLE);
    assign ext_rd_n  = !((seq_q.ph == PH_ACTIVE) && !seq_q.we);
    assign ext_wr_n  = !((seq_q.ph == PH_ACTIVE) &&  seq_q.we);

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph != PH_IDLE && $past(seq_q.ph) != PH_IDLE) |-> $stable(seq_q.addr));

    assert_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_ACTIVE && seq_q.cnt == '0 && !use_rdy) |=> (seq_q.ph != PH_ACTIVE));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_ACTIVE && seq_q.cnt == '0 && use_rdy && !rdy_smp)
            |=> (seq_q.ph == PH_ACTIVE && seq_q.cnt == '0));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ack |=> !seq_q.ack);

    assert_ack_after_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.ack) |-> ($past(seq_q.ph) != PH_IDLE));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph != PH_ACTIVE) |=> $stable(seq_q.rdata));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit ALLOW_X2    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cfg_rd_lead,
    input  logic [CNT_W-1:0]  cfg_rd_act,
    input  logic [CNT_W-1:0]  cfg_rd_trail,
    input  logic [CNT_W-1:0]  cfg_wr_lead,
    input  logic [CNT_W-1:0]  cfg_wr_act,
    input  logic [CNT_W-1:0]  cfg_wr_trail,
    input  logic              cfg_x2,
    input  logic              cfg_use_rdy,
    input  logic              cfg_rdy_async,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    input  logic              ext_rdy
);

    localparam int LW = CNT_W + 1;

    logic          sel_we;
    logic          rdy_smp;
    logic [LW-1:0] lead_len, act_len, trail_len;

    xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy_in     (ext_rdy),
        .async_mode (cfg_rdy_async),
        .rdy_smp    (rdy_smp)
    );

    xbus_len_sel #(.CNT_W(CNT_W), .ALLOW_X2(ALLOW_X2)) u_len (
        .sel_we    (sel_we),
        .rd_lead   (cfg_rd_lead),
        .rd_act    (cfg_rd_act),
        .rd_trail  (cfg_rd_trail),
        .wr_lead   (cfg_wr_lead),
        .wr_act    (cfg_wr_act),
        .wr_trail  (cfg_wr_trail),
        .x2        (cfg_x2),
        .lead_len  (lead_len),
        .act_len   (act_len),
        .trail_len (trail_len)
    );

    xbus_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LW(LW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lead_len  (lead_len),
        .act_len   (act_len),
        .trail_len (trail_len),
        .use_rdy   (cfg_use_rdy),
        .rdy_smp   (rdy_smp),
        .ext_rdata (ext_rdata),
        .sel_we    (sel_we),
        .ack       (ack),
        .rd_data   (rd_data),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_cs_n  (ext_cs_n),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n)
    );

endmodule

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        ack;
    logic [15:0] rd_data;
    logic [2:0]  cfg_rd_lead = '0, cfg_rd_act = '0, cfg_rd_trail = '0;
    logic [2:0]  cfg_wr_lead = '0, cfg_wr_act = '0, cfg_wr_trail = '0;
    logic        cfg_x2 = 1'b0, cfg_use_rdy = 1'b0, cfg_rdy_async = 1'b0;
    logic [15:0] ext_addr, ext_wdata;
    logic [15:0] ext_rdata = '0;
    logic        ext_cs_n, ext_rd_n, ext_wr_n;
    logic        ext_rdy = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    xbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
        .cfg_rd_lead(cfg_rd_lead), .cfg_rd_act(cfg_rd_act), .cfg_rd_trail(cfg_rd_trail),
        .cfg_wr_lead(cfg_wr_lead), .cfg_wr_act(cfg_wr_act), .cfg_wr_trail(cfg_wr_trail),
        .cfg_x2(cfg_x2), .cfg_use_rdy(cfg_use_rdy), .cfg_rdy_async(cfg_rdy_async),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rdy(ext_rdy)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] lead;
        logic [2:0] act;
        logic [2:0] trail;
        logic       x2;
        logic       use_rdy;
        logic       async_m;
        logic [3:0] rdy_at;   // 0: ready high throughout; else raised after that many strobe cycles
        logic [4:0] exp_cs;
        logic [4:0] exp_st;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0,  5'd3,  5'd2},  // plain read
        '{1'b1, 3'd2, 3'd3, 3'd1, 1'b0, 1'b0, 1'b0, 4'd0,  5'd6,  5'd3},  // plain write
        '{1'b0, 3'd1, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0, 4'd0,  5'd6,  5'd2},  // R4 doubling
        '{1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0,  5'd1,  5'd1},  // R3 zero active
        '{1'b1, 3'd1, 3'd2, 3'd0, 1'b0, 1'b1, 1'b0, 4'd5,  5'd6,  5'd5},  // R7 waits
        '{1'b0, 3'd1, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0, 4'd1,  5'd5,  5'd2},  // R7 early ready
        '{1'b0, 3'd1, 3'd2, 3'd0, 1'b0, 1'b1, 1'b1, 4'd4,  5'd7,  5'd6},  // R8 two-cycle lag
        '{1'b1, 3'd1, 3'd1, 3'd0, 1'b1, 1'b1, 1'b1, 4'd0,  5'd4,  5'd2},  // R8 ready high
        '{1'b1, 3'd2, 3'd1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd15, 5'd4,  5'd1},  // R6 ready ignored
        '{1'b0, 3'd3, 3'd2, 3'd3, 1'b1, 1'b1, 1'b0, 4'd0,  5'd16, 5'd4}   // R4 long doubled
    };

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic report_end;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic string st_tag(input int i, input vec_t v);
        if (i == 3)                    return "R3 strobe length";
        if (v.use_rdy && v.async_m)    return "R8 strobe length";
        if (v.use_rdy)                 return "R7 strobe length";
        if (v.rdy_at != 0)             return "R6 strobe length";
        if (v.x2)                      return "R4 strobe length";
        return "R5 strobe length";
    endfunction

    task automatic run_vec(input int i);
        vec_t        v;
        int          cs_cnt, st_cnt, ack_cnt, bad_bus, bad_dir, guard;
        bit          seen_st, ack_cs_ok, done;
        logic [15:0] a, wd, rdv;
        v = VECS[i];
        if (v.we) begin
            cfg_wr_lead = v.lead; cfg_wr_act = v.act; cfg_wr_trail = v.trail;
            cfg_rd_lead = 3'd7;   cfg_rd_act = 3'd7;  cfg_rd_trail = 3'd7;
        end else begin
            cfg_rd_lead = v.lead; cfg_rd_act = v.act; cfg_rd_trail = v.trail;
            cfg_wr_lead = 3'd7;   cfg_wr_act = 3'd7;  cfg_wr_trail = 3'd7;
        end
        cfg_x2 = v.x2; cfg_use_rdy = v.use_rdy; cfg_rdy_async = v.async_m;
        ext_rdy = (v.rdy_at == 0);
        rdv = 16'hC000 | 16'(i);
        ext_rdata = rdv;
        repeat (4) @(negedge clk);
        a  = 16'h1000 + 16'(i) * 16'h0111;
        wd = 16'hA5A0 ^ 16'(i);
        req = 1'b1; req_we = v.we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        cs_cnt = 0; st_cnt = 0; ack_cnt = 0; bad_bus = 0; bad_dir = 0; guard = 0;
        seen_st = 0; ack_cs_ok = 0; done = 0;
        while (!done) begin
            if (!ext_cs_n) begin
                cs_cnt++;
                if (ext_addr !== a) bad_bus++;
            end
            if (!ext_rd_n || !ext_wr_n) begin
                st_cnt++;
                seen_st = 1;
                if ((v.we && !ext_rd_n) || (!v.we && !ext_wr_n)) bad_dir++;
                if (v.we && ext_wdata !== wd) bad_bus++;
                if (st_cnt == int'(v.rdy_at)) ext_rdy = 1'b1;
            end else if (seen_st) begin
                ext_rdata = 16'h5555;
            end
            if (ack) begin
                ack_cnt++;
                ack_cs_ok = ext_cs_n;
                done = 1;
            end
            guard++;
            if (guard > 300) begin
                done = 1;
                check(1'b0, "R9 access timeout", guard, int'(v.exp_cs));
            end
            if (!done) @(negedge clk);
        end
        @(negedge clk);
        check(cs_cnt == int'(v.exp_cs), "R2 chip-select length", cs_cnt, int'(v.exp_cs));
        check(st_cnt == int'(v.exp_st), st_tag(i, v), st_cnt, int'(v.exp_st));
        check(bad_bus == 0, "R1 address/data held", bad_bus, 0);
        check(bad_dir == 0, "R5 strobe direction", bad_dir, 0);
        check(ack_cnt == 1 && ack_cs_ok && !ack, "R9 ack single pulse after cycle",
              {ack_cnt, 1'(ack_cs_ok), 1'(ack)}, {32'd1, 1'b1, 1'b0});
        if (!v.we) last_rd = rdv;
        check(rd_data === last_rd, "R10 read capture", rd_data, last_rd);
    endtask

    task automatic run_overlap;
        int ack_cnt, cs_cnt, bad_addr;
        cfg_rd_lead = 3'd2; cfg_rd_act = 3'd2; cfg_rd_trail = 3'd2;
        cfg_x2 = 0; cfg_use_rdy = 0; cfg_rdy_async = 0;
        repeat (3) @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 16'h2222;
        @(negedge clk);
        req = 1'b0;
        ack_cnt = 0; cs_cnt = 0; bad_addr = 0;
        for (int n = 0; n < 25; n++) begin
            if (!ext_cs_n) begin
                cs_cnt++;
                if (ext_addr !== 16'h2222) bad_addr++;
            end
            if (ack) ack_cnt++;
            if (n == 2) begin req = 1'b1; req_addr = 16'h3333; end
            if (n == 3) req = 1'b0;
            @(negedge clk);
        end
        check(ack_cnt == 1, "R12 single ack for overlapped req", ack_cnt, 1);
        check(cs_cnt == 6, "R12 single cycle on bus", cs_cnt, 6);
        check(bad_addr == 0, "R12 address unchanged", bad_addr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R9 watchdog: actual=no end expected=end of run");
        report_end();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs while reset is asserted and just after release
        check(ext_cs_n && ext_rd_n && ext_wr_n && !ack, "R11 reset strobes",
              {ext_cs_n, ext_rd_n, ext_wr_n, ack}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data === 16'h0000, "R11 reset read data", rd_data, 0);
        check(ext_cs_n && ext_rd_n && ext_wr_n && !ack, "R11 idle after reset",
              {ext_cs_n, ext_rd_n, ext_wr_n, ack}, 4'b1110);
        for (int i = 0; i < NV; i++) run_vec(i);
        run_overlap();
        // R6: with ready use off, ready low during idle leaves the bus idle
        ext_rdy = 1'b0;
        repeat (4) @(negedge clk);
        check(ext_cs_n && ext_rd_n && ext_wr_n, "R6 idle bus with ready low",
              {ext_cs_n, ext_rd_n, ext_wr_n}, 3'b111);
        report_end();
        $finish;
    end

endmodule